// File: doc/BRIEF.md
# Dual-Header CRC Boot Sequencer

This block takes control right after reset and decides where the processor begins. It reads a five-word boot header from a fixed memory location and verifies the header with a 32-bit CRC. If the header is good, it computes a CRC over the code range that the header describes and compares it with the value stored in the header. When both checks pass, the block reports the program start address held in the header and pulses a done strobe.

A failure of any kind on the primary header makes the block repeat the same procedure on a secondary header at a second fixed location. If the secondary header also fails, no jump is issued. Instead, the block selects one of three serial bootstrap loader modes from a 3-bit option value that it latched from pins while reset was held. Option codes with no assigned loader raise an error flag.

All memory traffic goes through a single synchronous read port. The port has an address, a one-cycle read strobe and a data-valid return. Only one read is in flight at a time, and the memory may take any number of cycles to answer.

Top module: `boot_crc_sequencer`

## Requirements
- R1: While `rst_n` is low and until the sequence ends, `boot_done`, `boot_jump` and `opt_bad` are 0, `boot_addr` is 0 and `ldr_mode` is 0. No read is strobed while reset is held.
- R2: A header occupies five consecutive words from its base address: +0 program start, +1 first range word, +2 last range word, +3 expected range CRC, +4 expected header CRC. The five header words are read in address order before any range word. The primary base is read first.
- R3: Both CRCs use polynomial 0x04C11DB7 with an all-ones start value, shift in one 32-bit word per update (most significant bit first), and are inverted at the end. The header CRC covers words +0 to +3 only.
- R4: The range check reads every word from the first to the last range address, both included. Range words are read only when the header CRC matches. A last address below the first address fails the header without any range read.
- R5: When both primary checks pass, `boot_addr` equals primary word +0, `boot_jump` is 1 and `ldr_mode` is 0.
- R6: When any primary check fails, the secondary header is processed by the same rules. If it passes, `boot_addr` equals secondary word +0 and `boot_jump` is 1.
- R7: When both headers fail, `boot_jump` stays 0 and `ldr_mode` follows the latched option: 3'b110 gives 1 (serial loader on its default pins), 3'b101 gives 2 (CAN loader) and 3'b111 gives 3 (serial loader on the pins shared with CAN).
- R8: When both headers fail and the latched option is any other code, `opt_bad` is 1, `ldr_mode` is 0 and `boot_jump` is 0.
- R9: The option value is the state of `opt_pins` at the last clock edge before `rst_n` rises. Changes to `opt_pins` after that edge do not change `ldr_mode`.
- R10: `boot_done` is high for exactly one cycle per reset. The result outputs take their final values in that same cycle and hold them, with no further reads, until the next reset.
- R11: `mem_rd` is never high in two consecutive cycles. After a strobe, the block waits for `mem_rvalid` however long it takes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; option pins are sampled while it is low |
| opt_pins | input | 3 | Loader option pins |
| mem_addr | output | ADDR_W | Word address of the current read |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_rdata | input | DATA_W | Read data, valid with `mem_rvalid` |
| mem_rvalid | input | 1 | Read data valid |
| boot_done | output | 1 | One-cycle pulse when the decision is made |
| boot_jump | output | 1 | 1 when `boot_addr` is a verified start address |
| boot_addr | output | ADDR_W | Verified program start address |
| ldr_mode | output | 2 | Fallback loader: 0 none, 1 serial default pins, 2 CAN, 3 serial shared pins |
| opt_bad | output | 1 | Both headers failed and the option code is reserved |

## Verification
A read strobe is followed by a data return whose delay the bench memory sets per scenario: one cycle in most tasks and three in two of them. The decision appears as a registered pulse after the last word is compared, so its exact cycle depends on the header contents. For that reason each task waits on `boot_done` at falling edges with a bounded timeout and samples every result in the pulse cycle. Five cycles later it samples again to confirm that the pulse has ended, the results are unchanged and the read count has not moved. Read counts and the logged read addresses are compared with the number and order of words that the requirements demand for each header outcome.

// File: rtl/boot_seq_pkg.sv
// Package: shared constants and types for the dual-header CRC boot sequencer.
// Assumes 32-bit CRC and header words at least as wide as addresses.
package boot_seq_pkg;

    localparam int CRC_W         = 32;
    localparam int HDR_WORDS     = 5;
    localparam int HDR_CRC_WORDS = 4;
    localparam int IDX_W         = $clog2(HDR_WORDS);

    // Word offsets inside a header
    localparam int HW_START = 0;
    localparam int HW_RBEG  = 1;
    localparam int HW_REND  = 2;
    localparam int HW_RCRC  = 3;
    localparam int HW_HCRC  = 4;

    // Option codes with an assigned loader
    localparam logic [2:0] OPT_SER_MAIN = 3'b110;
    localparam logic [2:0] OPT_CAN      = 3'b101;
    localparam logic [2:0] OPT_SER_ALT  = 3'b111;

    typedef enum logic [1:0] {
        LDR_NONE     = 2'd0,
        LDR_SER_MAIN = 2'd1,
        LDR_CAN      = 2'd2,
        LDR_SER_ALT  = 2'd3
    } ldr_mode_e;

    typedef enum logic [3:0] {
        S_INIT, S_HRD, S_HWT, S_HCHK, S_RRD, S_RWT, S_RCHK, S_FAIL, S_END
    } seq_state_e;

endpackage

// File: rtl/boot_crc32_step.sv
// Module: one combinational CRC update over a full data word, MSB first.
// Assumes DATA_W bits are absorbed per call; no state is held here.
module boot_crc32_step #(
    parameter int                                DATA_W = 32,
    parameter logic [boot_seq_pkg::CRC_W-1:0]    POLY   = 32'h04C11DB7
) (
    input  logic [boot_seq_pkg::CRC_W-1:0] crc_i,
    input  logic [DATA_W-1:0]              data_i,
    output logic [boot_seq_pkg::CRC_W-1:0] crc_o
);
    import boot_seq_pkg::*;

    logic [CRC_W-1:0] acc;
    logic             fb;

    // Shift every data bit through the linear feedback register
    always_comb begin
        acc = crc_i;
        fb  = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ data_i[i];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ POLY;
            end
        end
        crc_o = acc;
    end

endmodule

// File: rtl/boot_opt_capture.sv
// Module: latches the loader option pins while reset is held and decodes them.
// Assumes rst_n is synchronous; the last sample before release is kept.
module boot_opt_capture (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              opt_pins,
    output boot_seq_pkg::ldr_mode_e mode_o,
    output logic                    bad_o
);
    import boot_seq_pkg::*;

    logic [2:0] opt_q;

    // Track the pins during reset, freeze them once reset is released
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opt_q <= opt_pins;
        end
    end

    // Map the latched code onto a loader selection
    always_comb begin
        bad_o = 1'b0;
        unique case (opt_q)
            OPT_SER_MAIN: mode_o = LDR_SER_MAIN;
            OPT_CAN:      mode_o = LDR_CAN;
            OPT_SER_ALT:  mode_o = LDR_SER_ALT;
            default: begin
                mode_o = LDR_NONE;
                bad_o  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/boot_seq_ctrl.sv
// Module: sequencing FSM. Reads a header, checks its CRC, then checks the code
// range, retrying once with the secondary header before falling back.
// Assumes one outstanding read and DATA_W >= ADDR_W, DATA_W >= CRC_W.
module boot_seq_ctrl #(
    parameter int                ADDR_W       = 32,
    parameter int                DATA_W       = 32,
    parameter logic [ADDR_W-1:0] PRI_HDR_ADDR = '0,
    parameter logic [ADDR_W-1:0] SEC_HDR_ADDR = ADDR_W'(16)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    output logic [ADDR_W-1:0]               mem_addr,
    output logic                            mem_rd,
    input  logic [DATA_W-1:0]               mem_rdata,
    input  logic                            mem_rvalid,
    output logic [boot_seq_pkg::CRC_W-1:0]  crc_q,
    input  logic [boot_seq_pkg::CRC_W-1:0]  crc_nxt,
    input  boot_seq_pkg::ldr_mode_e         opt_mode,
    input  logic                            opt_reserved,
    output logic                            boot_done,
    output logic                            boot_jump,
    output logic [ADDR_W-1:0]               boot_addr,
    output boot_seq_pkg::ldr_mode_e         ldr_mode,
    output logic                            opt_bad
);
    import boot_seq_pkg::*;

    localparam logic [CRC_W-1:0] CRC_INIT = '1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_WORDS - 1);
    localparam logic [IDX_W-1:0] IDX_CRCN = IDX_W'(HDR_CRC_WORDS);

    seq_state_e        state_q;
    logic              use_sec_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] hdr_q [HDR_WORDS];
    logic [ADDR_W-1:0] ptr_q;

    logic [ADDR_W-1:0] hdr_base;
    logic [ADDR_W-1:0] rng_beg;
    logic [ADDR_W-1:0] rng_end;
    logic              hdr_ok;
    logic              rng_ok;

    // Decode header fields and the pass conditions
    always_comb begin
        hdr_base = use_sec_q ? SEC_HDR_ADDR : PRI_HDR_ADDR;
        rng_beg  = hdr_q[HW_RBEG][ADDR_W-1:0];
        rng_end  = hdr_q[HW_REND][ADDR_W-1:0];
        hdr_ok   = (~crc_q == hdr_q[HW_HCRC][CRC_W-1:0]) && !(rng_end < rng_beg);
        rng_ok   = (~crc_q == hdr_q[HW_RCRC][CRC_W-1:0]);
    end

    // Drive the memory read port from the current state
    always_comb begin
        mem_rd   = (state_q == S_HRD) || (state_q == S_RRD);
        mem_addr = (state_q == S_HRD) ? hdr_base + ADDR_W'(idx_q) : ptr_q;
    end

    // Main sequencing state machine and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_INIT;
            use_sec_q <= 1'b0;
            idx_q     <= '0;
            ptr_q     <= '0;
            crc_q     <= CRC_INIT;
            for (int i = 0; i < HDR_WORDS; i++) begin
                hdr_q[i] <= '0;
            end
            boot_done <= 1'b0;
            boot_jump <= 1'b0;
            boot_addr <= '0;
            ldr_mode  <= LDR_NONE;
            opt_bad   <= 1'b0;
        end else begin
            boot_done <= 1'b0;
            unique case (state_q)
                S_INIT: begin
                    use_sec_q <= 1'b0;
                    idx_q     <= '0;
                    crc_q     <= CRC_INIT;
                    state_q   <= S_HRD;
                end
                S_HRD: state_q <= S_HWT;
                S_HWT: begin
                    if (mem_rvalid) begin
                        hdr_q[idx_q] <= mem_rdata;
                        if (idx_q < IDX_CRCN) begin
                            crc_q <= crc_nxt;
                        end
                        if (idx_q == IDX_LAST) begin
                            state_q <= S_HCHK;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= S_HRD;
                        end
                    end
                end
                S_HCHK: begin
                    if (hdr_ok) begin
                        crc_q   <= CRC_INIT;
                        ptr_q   <= rng_beg;
                        state_q <= S_RRD;
                    end else begin
                        state_q <= S_FAIL;
                    end
                end
                S_RRD: state_q <= S_RWT;
                S_RWT: begin
                    if (mem_rvalid) begin
                        crc_q <= crc_nxt;
                        if (ptr_q == rng_end) begin
                            state_q <= S_RCHK;
                        end else begin
                            ptr_q   <= ptr_q + 1'b1;
                            state_q <= S_RRD;
                        end
                    end
                end
                S_RCHK: begin
                    if (rng_ok) begin
                        boot_addr <= hdr_q[HW_START][ADDR_W-1:0];
                        boot_jump <= 1'b1;
                        boot_done <= 1'b1;
                        state_q   <= S_END;
                    end else begin
                        state_q <= S_FAIL;
                    end
                end
                S_FAIL: begin
                    if (!use_sec_q) begin
                        use_sec_q <= 1'b1;
                        idx_q     <= '0;
                        crc_q     <= CRC_INIT;
                        state_q   <= S_HRD;
                    end else begin
                        ldr_mode  <= opt_mode;
                        opt_bad   <= opt_reserved;
                        boot_done <= 1'b1;
                        state_q   <= S_END;
                    end
                end
                default: state_q <= S_END;
            endcase
        end
    end

endmodule

// File: rtl/boot_crc_sequencer.sv
// Module: top of the dual-header CRC boot sequencer. Wires the option latch,
// the CRC word step and the control FSM together.
// Assumes memory answers every strobe exactly once with mem_rvalid.
module boot_crc_sequencer #(
    parameter int                ADDR_W       = 32,
    parameter int                DATA_W       = 32,
    parameter logic [ADDR_W-1:0] PRI_HDR_ADDR = '0,
    parameter logic [ADDR_W-1:0] SEC_HDR_ADDR = ADDR_W'(16)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        opt_pins,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    output logic              boot_done,
    output logic              boot_jump,
    output logic [ADDR_W-1:0] boot_addr,
    output logic [1:0]        ldr_mode,
    output logic              opt_bad
);
    import boot_seq_pkg::*;

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nxt;
    ldr_mode_e        opt_mode;
    logic             opt_reserved;
    ldr_mode_e        mode_r;

    boot_opt_capture u_opt (
        .clk      (clk),
        .rst_n    (rst_n),
        .opt_pins (opt_pins),
        .mode_o   (opt_mode),
        .bad_o    (opt_reserved)
    );

    boot_crc32_step #(
        .DATA_W (DATA_W)
    ) u_crc (
        .crc_i  (crc_q),
        .data_i (mem_rdata),
        .crc_o  (crc_nxt)
    );

    boot_seq_ctrl #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .PRI_HDR_ADDR (PRI_HDR_ADDR),
        .SEC_HDR_ADDR (SEC_HDR_ADDR)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mem_addr     (mem_addr),
        .mem_rd       (mem_rd),
        .mem_rdata    (mem_rdata),
        .mem_rvalid   (mem_rvalid),
        .crc_q        (crc_q),
        .crc_nxt      (crc_nxt),
        .opt_mode     (opt_mode),
        .opt_reserved (opt_reserved),
        .boot_done    (boot_done),
        .boot_jump    (boot_jump),
        .boot_addr    (boot_addr),
        .ldr_mode     (mode_r),
        .opt_bad      (opt_bad)
    );

    // Present the loader selection as a plain vector
    assign ldr_mode = mode_r;

endmodule

// File: rtl/boot_seq_chk.sv
// Module: assertion checker for the boot sequencer, bound to the top.
// Assumes it sees only top-level ports.
module boot_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic              boot_done,
    input logic              boot_jump,
    input logic [ADDR_W-1:0] boot_addr,
    input logic [1:0]        ldr_mode,
    input logic              opt_bad
);
    logic seen_q;

    // Remember that the decision has been reported since reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (boot_done) begin
            seen_q <= 1'b1;
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> !boot_done);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ($stable(boot_addr) && $stable(ldr_mode) && $stable(boot_jump)
                    && $stable(opt_bad) && !mem_rd && !boot_done));

    // R1
    quiet_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q && !boot_done) |-> (!boot_jump && ldr_mode == 2'd0 && !opt_bad));

    // R11
    single_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R5
    jump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_jump |-> (ldr_mode == 2'd0 && !opt_bad));

    // R8
    reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opt_bad |-> (ldr_mode == 2'd0 && !boot_jump));

endmodule

bind boot_crc_sequencer boot_seq_chk #(.ADDR_W(ADDR_W)) u_boot_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .boot_done (boot_done),
    .boot_jump (boot_jump),
    .boot_addr (boot_addr),
    .ldr_mode  (ldr_mode),
    .opt_bad   (opt_bad)
);

// File: tb/test_boot_crc_sequencer.sv
// Directed bench: one task per scenario, each checking its own results.
module test_boot_crc_sequencer;

    localparam int PRI = 'h00;
    localparam int SEC = 'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  opt_pins = 3'b000;
    logic [31:0] mem_addr;
    logic        mem_rd;
    logic [31:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        boot_done;
    logic        boot_jump;
    logic [31:0] boot_addr;
    logic [1:0]  ldr_mode;
    logic        opt_bad;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [256];
    int          lat = 1;
    logic [31:0] a_q = '0;
    int          cnt = 0;
    int          nrd = 0;
    logic [31:0] rd_log [64];

    always #2.5 clk = ~clk;

    boot_crc_sequencer #(
        .PRI_HDR_ADDR (32'(PRI)),
        .SEC_HDR_ADDR (32'(SEC))
    ) i_boot_crc_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .opt_pins   (opt_pins),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_rdata  (mem_rdata),
        .mem_rvalid (mem_rvalid),
        .boot_done  (boot_done),
        .boot_jump  (boot_jump),
        .boot_addr  (boot_addr),
        .ldr_mode   (ldr_mode),
        .opt_bad    (opt_bad)
    );

    // Memory model: answers each strobe after lat cycles
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_rd) begin
            a_q <= mem_addr;
            cnt <= lat;
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[a_q[7:0]];
            end
        end
    end

    // Read logger
    always @(posedge clk) begin
        if (!rst_n) begin
            nrd = 0;
        end else if (mem_rd) begin
            if (nrd < 64) rd_log[nrd] = mem_addr;
            nrd++;
        end
    end

    function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r = c;
        for (int b = 31; b >= 0; b--) begin
            if (r[31] ^ d[b]) r = (r << 1) ^ 32'h04C11DB7;
            else              r = r << 1;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD0000 | 32'(i);
    endtask

    task automatic fill_hdr(input int base, input logic [31:0] pc, input int rb, input int re,
                            input bit bad_hdr, input bit bad_rng);
        logic [31:0] c = 32'hFFFFFFFF;
        logic [31:0] h = 32'hFFFFFFFF;
        for (int a = rb; a <= re; a++) begin
            mem[a] = 32'h5A3C0000 ^ (32'(a) * 32'h01030507);
            c = crc_upd(c, mem[a]);
        end
        c = ~c;
        if (bad_rng) c = c ^ 32'h1;
        mem[base]     = pc;
        mem[base + 1] = 32'(rb);
        mem[base + 2] = 32'(re);
        mem[base + 3] = c;
        for (int i = 0; i < 4; i++) h = crc_upd(h, mem[base + i]);
        h = ~h;
        if (bad_hdr) h = h ^ 32'h1;
        mem[base + 4] = h;
    endtask

    // Reset with opt_rst latched, then drive opt_run; wait for the done pulse
    task automatic run_boot(input logic [2:0] opt_rst, input logic [2:0] opt_run, input int l);
        int cyc = 0;
        lat = l;
        @(negedge clk);
        rst_n    = 1'b0;
        opt_pins = opt_rst;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        opt_pins = opt_run;
        while (!boot_done && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
        chk("R10 done seen", 32'(boot_done), 32'h1);
    endtask

    // Confirm the pulse ended and results held with no more reads
    task automatic check_hold(input string req);
        logic [31:0] a = boot_addr;
        logic [1:0]  m = ldr_mode;
        logic        j = boot_jump;
        logic        b = opt_bad;
        int          n = nrd;
        repeat (5) @(negedge clk);
        chk({req, " R10 pulse ended"}, 32'(boot_done), 32'h0);
        chk({req, " R10 held"}, {boot_addr ^ a, 2'b0, ldr_mode ^ m, boot_jump ^ j, opt_bad ^ b}, 32'h0);
        chk({req, " R10 no reads"}, 32'(nrd), 32'(n));
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset done", 32'(boot_done), 32'h0);
        chk("R1 reset outputs", {boot_addr[29:0], boot_jump, opt_bad}, 32'h0);
        chk("R1 reset mode", 32'(ldr_mode), 32'h0);
        chk("R1 reset no read", 32'(mem_rd), 32'h0);
    endtask

    task automatic t_pri_pass();
        clear_mem();
        fill_hdr(PRI, 32'h8000_1000, 'h40, 'h47, 0, 0);
        fill_hdr(SEC, 32'h9000_2000, 'h80, 'h83, 0, 0);
        run_boot(3'b110, 3'b110, 1);
        chk("R5 addr", boot_addr, 32'h8000_1000);
        chk("R5 jump", 32'(boot_jump), 32'h1);
        chk("R5 mode", 32'(ldr_mode), 32'h0);
        chk("R4 R3 read count", 32'(nrd), 32'(5 + 8));
        for (int i = 0; i < 5; i++) chk("R2 header order", rd_log[i], 32'(PRI + i));
        chk("R4 first range", rd_log[5], 32'h40);
        chk("R4 last range", rd_log[12], 32'h47);
        check_hold("pri_pass");
    endtask

    task automatic t_pri_hdr_bad();
        clear_mem();
        fill_hdr(PRI, 32'h8000_1000, 'h40, 'h47, 1, 0);
        fill_hdr(SEC, 32'h9000_2000, 'h80, 'h83, 0, 0);
        run_boot(3'b110, 3'b110, 3);
        chk("R6 addr", boot_addr, 32'h9000_2000);
        chk("R6 jump", 32'(boot_jump), 32'h1);
        chk("R4 no range read on bad header", 32'(nrd), 32'(10 + 4));
        for (int i = 0; i < 5; i++) chk("R2 sec header order", rd_log[5 + i], 32'(SEC + i));
        check_hold("pri_hdr_bad");
    endtask

    task automatic t_pri_rng_bad();
        clear_mem();
        fill_hdr(PRI, 32'h8000_1000, 'h40, 'h45, 0, 1);
        fill_hdr(SEC, 32'h9000_3000, 'h80, 'h82, 0, 0);
        run_boot(3'b101, 3'b101, 1);
        chk("R6 range fail addr", boot_addr, 32'h9000_3000);
        chk("R6 range fail jump", 32'(boot_jump), 32'h1);
        chk("R4 R6 read count", 32'(nrd), 32'(5 + 6 + 5 + 3));
    endtask

    task automatic t_inverted();
        clear_mem();
        fill_hdr(PRI, 32'h8000_1000, 'h50, 'h4F, 0, 0);
        fill_hdr(SEC, 32'h9000_4000, 'h80, 'h80, 0, 0);
        run_boot(3'b111, 3'b111, 1);
        chk("R4 inverted range addr", boot_addr, 32'h9000_4000);
        chk("R4 inverted range reads", 32'(nrd), 32'(10 + 1));
    endtask

    task automatic t_single_word();
        clear_mem();
        fill_hdr(PRI, 32'h8000_5000, 'h60, 'h60, 0, 0);
        run_boot(3'b000, 3'b000, 3);
        chk("R4 single word addr", boot_addr, 32'h8000_5000);
        chk("R4 single word reads", 32'(nrd), 32'(6));
        chk("R5 no error on pass", 32'(opt_bad), 32'h0);
    endtask

    task automatic t_double(input logic [2:0] opt, input logic [1:0] mode, input bit bad);
        clear_mem();
        fill_hdr(PRI, 32'h8000_1000, 'h40, 'h43, 1, 0);
        fill_hdr(SEC, 32'h9000_2000, 'h80, 'h83, 0, 1);
        run_boot(opt, opt, 1);
        chk(bad ? "R8 mode" : "R7 mode", 32'(ldr_mode), 32'(mode));
        chk(bad ? "R8 flag" : "R7 flag", 32'(opt_bad), 32'(bad));
        chk("R7 no jump", 32'(boot_jump), 32'h0);
        chk("R7 reads", 32'(nrd), 32'(5 + 5 + 4));
        check_hold("double");
    endtask

    task automatic t_opt_change();
        clear_mem();
        fill_hdr(PRI, 32'h8000_1000, 'h40, 'h43, 1, 0);
        fill_hdr(SEC, 32'h9000_2000, 'h80, 'h83, 1, 0);
        run_boot(3'b101, 3'b110, 1);
        chk("R9 pins ignored after release", 32'(ldr_mode), 32'h2);
        opt_pins = 3'b000;
        repeat (3) @(negedge clk);
        chk("R9 late pin change", {30'h0, ldr_mode}, 32'h2);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_mem();
        t_reset();
        t_pri_pass();
        t_pri_hdr_bad();
        t_pri_rng_bad();
        t_inverted();
        t_single_word();
        t_double(3'b110, 2'd1, 1'b0);
        t_double(3'b101, 2'd2, 1'b0);
        t_double(3'b111, 2'd3, 1'b0);
        t_double(3'b000, 2'd0, 1'b1);
        t_double(3'b100, 2'd0, 1'b1);
        t_opt_change();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule